// File: doc/BRIEF.md
# Burst SRAM Bus-Cycle Sequencer

This block sits behind the control pins of a pipelined burst SRAM port. Each rising clock edge it samples three active-low style command strobes, an order select and an address. It then decides whether the cycle starts a new burst, continues the one in progress, or idles. For every accepted cycle it presents one beat address to the memory array in single-rate mode, or two beat addresses in double-rate mode. Each beat comes with a valid strobe and a read/write indication.

The burst window is four beats. Beats advance through that window in either counting (linear) order or XOR (interleaved) order. A continue past the end of the window wraps the two low address bits within the same group. One cycle after each read access the block raises the data-output enable, and a second flag shows that both half-cycle beats are driven. The block also reports two protocol faults: a continue with no operation in progress, and a write that follows a read with no idle cycle between them.

Top module: `bseq_top`

## Requirements
- R1: While reset is high at a clock edge, and after that edge, all beat valids, the write indication, both output enables and both error flags are 0.
- R2: A cycle with `ldN`=0 starts a new operation at the address on `addrIn`. `rdWrN`=1 selects a read and 0 selects a write. `sdrDdrN`=1 gives one beat per cycle (`beatVld0` only) and 0 gives two beats per cycle (`beatVld0` and `beatVld1`). The beat outputs are valid in the cycle that follows the sampling edge.
- R3: With `burstIlv`=0 at the load, beat k of the burst has low two address bits equal to (start + k) mod 4.
- R4: With `burstIlv`=1 at the load, beat k has low two address bits equal to start XOR k.
- R5: A continue (`ldN`=1, `rdWrN`=1) during an active operation repeats its direction. It advances the beat index by 1 in single-rate mode and by 2 in double-rate mode. Any number of continues is accepted, the index wraps within the four-beat group, and address bits above bit 1 never change.
- R6: A no-op (`ldN`=1, `rdWrN`=0) ends the current operation and produces no beat in the next cycle.
- R7: `dqOe` is 1 exactly in the cycle after a cycle that issued a read beat. `dqDual` is 1 exactly in the cycle after a cycle that issued two read beats. Both are 0 one cycle after a no-op.
- R8: A continue while no operation is active raises `contErr` for one cycle and issues no beat.
- R9: A write load in the cycle right after a read access raises `turnErr` for one cycle, and the write is still issued.
- R10: The order and rate selects are taken only at a load. Changing them during continues does not change the address sequence or the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ldN | input | 1 | 0 = load a new address and operation |
| rdWrN | input | 1 | At load: 1 read, 0 write. Otherwise: 1 continue, 0 no-op |
| sdrDdrN | input | 1 | At load: 1 single rate, 0 double rate |
| burstIlv | input | 1 | At load: 1 interleaved order, 0 linear order |
| addrIn | input | ADDR_W | Start address |
| beatAddr0 | output | ADDR_W | First beat address of the cycle |
| beatAddr1 | output | ADDR_W | Second beat address (double rate) |
| beatVld0 | output | 1 | First beat is valid |
| beatVld1 | output | 1 | Second beat is valid |
| beatWr | output | 1 | Valid beats are writes |
| dqOe | output | 1 | Data output enable |
| dqDual | output | 1 | Both half-cycle output beats driven |
| turnErr | output | 1 | Read-to-write turnaround violation |
| contErr | output | 1 | Continue with no active operation |

## Verification
A wrong burst index or a wrong stored order shows on `beatAddr0`/`beatAddr1` in the very next continue cycle, so every continue is compared at the beat ports. A lost or stale active flag shows as a missing or spurious beat valid one edge later. Misplaced read history shows on `dqOe`, `dqDual` or `turnErr` one cycle after the cycle it corrupts. Long random command streams mixed with directed wrap, rate-change and turnaround cases bring each of these faults to the ports within one or two cycles.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Control-to-datapath strobes for one clock cycle
  typedef struct packed {
    logic loadNow;  // new start address and mode
    logic stepNow;  // advance the burst index
    logic ddrNow;   // rate captured at load
    logic ilvNow;   // order captured at load
  } seqStrobe_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ldN,
  input  logic       rdWrN,
  input  logic       sdrDdrN,
  input  logic       burstIlv,
  output seqStrobe_t strobe,
  output logic       beatVld0,
  output logic       beatVld1,
  output logic       beatWr,
  output logic       dqOe,
  output logic       dqDual,
  output logic       turnErr,
  output logic       contErr
);

  logic activeQ, opWrQ, opDdrQ, lastRdQ;
  logic isLoad, isCont, goodCont, badCont, isNoop;

  always_comb begin
    isLoad   = !ldN;
    isCont   = ldN && rdWrN;
    isNoop   = ldN && !rdWrN;
    goodCont = isCont && activeQ;
    badCont  = isCont && !activeQ;
    strobe.loadNow = isLoad;
    strobe.stepNow = goodCont;
    strobe.ddrNow  = !sdrDdrN;
    strobe.ilvNow  = burstIlv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ  <= 1'b0;
      opWrQ    <= 1'b0;
      opDdrQ   <= 1'b0;
      lastRdQ  <= 1'b0;
      beatVld0 <= 1'b0;
      beatVld1 <= 1'b0;
      beatWr   <= 1'b0;
      dqOe     <= 1'b0;
      dqDual   <= 1'b0;
      turnErr  <= 1'b0;
      contErr  <= 1'b0;
    end else begin
      dqOe    <= beatVld0 && !beatWr;
      dqDual  <= beatVld1 && !beatWr;
      turnErr <= isLoad && !rdWrN && lastRdQ;
      contErr <= badCont;
      if (isLoad) begin
        activeQ  <= 1'b1;
        opWrQ    <= !rdWrN;
        opDdrQ   <= !sdrDdrN;
        beatVld0 <= 1'b1;
        beatVld1 <= !sdrDdrN;
        beatWr   <= !rdWrN;
        lastRdQ  <= rdWrN;
      end else if (goodCont) begin
        beatVld0 <= 1'b1;
        beatVld1 <= opDdrQ;
        beatWr   <= opWrQ;
        lastRdQ  <= !opWrQ;
      end else begin
        activeQ  <= 1'b0;
        beatVld0 <= 1'b0;
        beatVld1 <= 1'b0;
        beatWr   <= 1'b0;
        lastRdQ  <= 1'b0;
      end
    end
  end

  // R2: a second beat never comes without the first
  assert_second_beat_R2: assert property (@(posedge clk) disable iff (rst)
    beatVld1 |-> beatVld0);

  // R6: a no-op leaves no beat behind it
  assert_noop_idle_R6: assert property (@(posedge clk) disable iff (rst)
    isNoop |=> !beatVld0 && !beatVld1);

  // R8: an invalid continue issues nothing, so no output enable follows
  assert_bad_cont_R8: assert property (@(posedge clk) disable iff (rst)
    contErr |-> !beatVld0 ##1 !dqOe);

  // R9: a turnaround fault is reported on an issued write
  assert_turn_write_R9: assert property (@(posedge clk) disable iff (rst)
    turnErr |-> beatVld0 && beatWr);

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] beat0Addr,
  output logic [ADDR_W-1:0] beat1Addr
);

  localparam int HI_W = ADDR_W - BEAT_BITS;
  localparam logic [BEAT_BITS-1:0] ONE = BEAT_BITS'(1);
  localparam logic [BEAT_BITS-1:0] TWO = BEAT_BITS'(2);

  logic [HI_W-1:0]      hiQ, curHi;
  logic [BEAT_BITS-1:0] startQ, idxQ, curStart, nextIdx;
  logic                 ilvQ, ddrQ, curIlv;

  function automatic logic [BEAT_BITS-1:0] orderLow(
    input logic [BEAT_BITS-1:0] s,
    input logic [BEAT_BITS-1:0] k,
    input logic                 ilv);
    return ilv ? (s ^ k) : (s + k);
  endfunction

  always_comb begin
    curHi    = strobe.loadNow ? addrIn[ADDR_W-1:BEAT_BITS] : hiQ;
    curStart = strobe.loadNow ? addrIn[BEAT_BITS-1:0] : startQ;
    curIlv   = strobe.loadNow ? strobe.ilvNow : ilvQ;
    nextIdx  = strobe.loadNow ? '0 : (idxQ + (ddrQ ? TWO : ONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiQ       <= '0;
      startQ    <= '0;
      idxQ      <= '0;
      ilvQ      <= 1'b0;
      ddrQ      <= 1'b0;
      beat0Addr <= '0;
      beat1Addr <= '0;
    end else if (strobe.loadNow || strobe.stepNow) begin
      hiQ       <= curHi;
      startQ    <= curStart;
      idxQ      <= nextIdx;
      ilvQ      <= curIlv;
      if (strobe.loadNow) ddrQ <= strobe.ddrNow;
      beat0Addr <= {curHi, orderLow(curStart, nextIdx, curIlv)};
      beat1Addr <= {curHi, orderLow(curStart, nextIdx + ONE, curIlv)};
    end
  end

  // R2: the first beat of a new operation is the loaded address itself
  assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.loadNow |=> beat0Addr == $past(addrIn));

  // R5: a continue keeps the address above the burst window
  assert_hi_stable_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.stepNow |=> beat0Addr[ADDR_W-1:BEAT_BITS] == $past(beat0Addr[ADDR_W-1:BEAT_BITS]));

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldN,
  input  logic              rdWrN,
  input  logic              sdrDdrN,
  input  logic              burstIlv,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] beatAddr0,
  output logic [ADDR_W-1:0] beatAddr1,
  output logic              beatVld0,
  output logic              beatVld1,
  output logic              beatWr,
  output logic              dqOe,
  output logic              dqDual,
  output logic              turnErr,
  output logic              contErr
);

  seqStrobe_t strobe;

  bseq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ldN      (ldN),
    .rdWrN    (rdWrN),
    .sdrDdrN  (sdrDdrN),
    .burstIlv (burstIlv),
    .strobe   (strobe),
    .beatVld0 (beatVld0),
    .beatVld1 (beatVld1),
    .beatWr   (beatWr),
    .dqOe     (dqOe),
    .dqDual   (dqDual),
    .turnErr  (turnErr),
    .contErr  (contErr)
  );

  bseq_addr #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .beat0Addr (beatAddr0),
    .beat1Addr (beatAddr1)
  );

endmodule

// File: tb/tb_bseq_top.sv
module tb_bseq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ldN = 1'b1, rdWrN = 1'b0, sdrDdrN = 1'b1, burstIlv = 1'b0;
  logic [19:0] addrIn = '0;
  logic [19:0] beatAddr0, beatAddr1;
  logic        beatVld0, beatVld1, beatWr, dqOe, dqDual, turnErr, contErr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  bseq_top dut (
    .clk(clk), .rst(rst), .ldN(ldN), .rdWrN(rdWrN), .sdrDdrN(sdrDdrN),
    .burstIlv(burstIlv), .addrIn(addrIn), .beatAddr0(beatAddr0),
    .beatAddr1(beatAddr1), .beatVld0(beatVld0), .beatVld1(beatVld1),
    .beatWr(beatWr), .dqOe(dqOe), .dqDual(dqDual), .turnErr(turnErr),
    .contErr(contErr)
  );

  // reference model state
  bit          mActive, mWr, mDdr, mIlv, mLastRd;
  logic [1:0]  mStart;
  logic [17:0] mHi;
  int          mIdx;
  bit          eV0, eV1, eWr, eOe, eDual, eTe, eCe;
  logic [19:0] eA0, eA1;

  function automatic logic [1:0] expLow(logic [1:0] s, int k, bit ilv);
    int v;
    if (ilv) v = int'(s) ^ (k % 4);
    else     v = (int'(s) + k) % 4;
    return v[1:0];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "beatVld0", 32'(beatVld0), 32'(eV0));
    chk(tag, "beatVld1", 32'(beatVld1), 32'(eV1));
    chk(tag, "beatWr",   32'(beatWr),   32'(eWr));
    chk(tag, "dqOe",     32'(dqOe),     32'(eOe));
    chk(tag, "dqDual",   32'(dqDual),   32'(eDual));
    chk(tag, "turnErr",  32'(turnErr),  32'(eTe));
    chk(tag, "contErr",  32'(contErr),  32'(eCe));
    if (eV0) chk(tag, "beatAddr0", 32'(beatAddr0), 32'(eA0));
    if (eV1) chk(tag, "beatAddr1", 32'(beatAddr1), 32'(eA1));
  endtask

  task automatic step(string tag, bit ld, bit rw, bit sd, bit ilv, logic [19:0] a);
    @(negedge clk);
    ldN = ld; rdWrN = rw; sdrDdrN = sd; burstIlv = ilv; addrIn = a;
    eOe   = eV0 && !eWr;
    eDual = eV1 && !eWr;
    eTe = 1'b0; eCe = 1'b0;
    if (!ld) begin
      eTe = !rw && mLastRd;
      mActive = 1'b1; mWr = !rw; mDdr = !sd; mIlv = ilv;
      mStart = a[1:0]; mHi = a[19:2]; mIdx = 0;
      eV0 = 1'b1; eV1 = !sd; eWr = !rw; mLastRd = rw;
    end else if (rw) begin
      if (mActive) begin
        mIdx = mIdx + (mDdr ? 2 : 1);
        eV0 = 1'b1; eV1 = mDdr; eWr = mWr; mLastRd = !mWr;
      end else begin
        eCe = 1'b1; eV0 = 1'b0; eV1 = 1'b0; eWr = 1'b0; mLastRd = 1'b0;
      end
    end else begin
      mActive = 1'b0; eV0 = 1'b0; eV1 = 1'b0; eWr = 1'b0; mLastRd = 1'b0;
    end
    eA0 = {mHi, expLow(mStart, mIdx, mIlv)};
    eA1 = {mHi, expLow(mStart, mIdx + 1, mIlv)};
    @(posedge clk);
    #1;
    checkAll(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R5: linear single-rate read from start 2, wrap past the window
    step("R2", 0, 1, 1, 0, 20'hABCD2);
    step("R3", 1, 1, 1, 0, 20'h0);
    step("R3", 1, 1, 1, 0, 20'h0);
    step("R3", 1, 1, 1, 0, 20'h0);
    step("R5", 1, 1, 1, 0, 20'h0);
    // R6 R7: no-op ends it, enable drops one cycle later
    step("R6", 1, 0, 1, 0, 20'h0);
    step("R7", 1, 0, 1, 0, 20'h0);

    // R4 R5 R7: interleaved double-rate read from start 1
    step("R4", 0, 1, 0, 1, 20'h12341);
    step("R4", 1, 1, 0, 1, 20'h0);
    step("R5", 1, 1, 0, 1, 20'h0);
    step("R7", 1, 0, 1, 0, 20'h0);
    step("R7", 1, 0, 1, 0, 20'h0);

    // R9: write straight after a read, then a legal write after a no-op
    step("R9", 0, 1, 1, 0, 20'h00010);
    step("R9", 0, 0, 0, 0, 20'h00023);
    step("R9", 1, 1, 0, 0, 20'h0);
    step("R9", 1, 0, 1, 0, 20'h0);
    step("R9", 0, 0, 1, 1, 20'h00043);

    // R8: continue with nothing active
    step("R8", 1, 0, 1, 0, 20'h0);
    step("R8", 1, 1, 1, 0, 20'h0);
    step("R8", 1, 1, 0, 1, 20'h0);

    // R10: selects flipped during continues are ignored
    step("R10", 0, 1, 1, 0, 20'hFFFF3);
    step("R10", 1, 1, 0, 1, 20'h0);
    step("R10", 1, 1, 0, 1, 20'h0);
    step("R10", 1, 0, 1, 0, 20'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2)
        step("R6", 1, 0, 1'($urandom), 1'($urandom), 20'($urandom));
      else if (r < 5)
        step("R2", 0, 1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom));
      else
        step("R5", 1, 1, 1'($urandom), 1'($urandom), 20'($urandom));
    end

    // R1: reset in the middle of a burst
    step("R1", 0, 1, 0, 0, 20'h55555);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    mActive = 0; mLastRd = 0; eV0 = 0; eV1 = 0; eWr = 0;
    eOe = 0; eDual = 0; eTe = 0; eCe = 0;
    checkAll("R1");
    summary();
  end

endmodule